// File: doc/BRIEF.md
# Dual-Line Up/Down Counter Stage

This block is a synchronous binary counter stage that has two separate count lines instead of a direction pin. A rising edge on the increment line adds one to the count, but only while the decrement line is held high. A rising edge on the decrement line subtracts one, but only while the increment line is held high. Both lines are treated as pulse inputs. Each passes through a synchronizer into the system clock domain, and its edges are found by comparing the current sampled value with the previous one. Every count bit is a flop on the single system clock, so all outputs change together on the same edge and the count shows no intermediate values.

A high-priority synchronous clear drives the count to zero. An active-low parallel load copies the data inputs into the count. Clear wins over load, and load wins over counting. For plain counting, hold load high and clear low.

Two active-low outputs allow stages to be chained into a wider counter:
- The wrap-up flag goes low while the count is at its maximum and the sampled increment line is low.
- The wrap-down flag goes low while the count is zero and the sampled decrement line is low.

To chain stages, connect the wrap-up flag to the next stage's increment line and the wrap-down flag to its decrement line, and share clear and load between all stages. Each stage added to the chain adds the synchronizer latency to the carry path.

Top module: `ucnt_cascade`

## Requirements
- R1: When rst_ni is low, or clr_i is high at a rising clock edge, the count goes to zero. clr_i wins over load_ni.
- R2: When load_ni is low at a rising clock edge and clr_i is low, cnt_o takes data_i on that edge. Any count event in the same cycle is discarded.
- R3: When dn_i is held high, a rising edge on up_i adds one to cnt_o. The count wraps from the all-ones value to zero. The new value appears on the third rising clock edge after up_i rises.
- R4: When up_i is held high, a rising edge on dn_i subtracts one from cnt_o. The count wraps from zero to all-ones. The timing is the same as in R3.
- R5: A rising edge on one count line has no effect on cnt_o while the other line is low. This includes the case where both lines rise on the same cycle.
- R6: carry_no is low exactly when cnt_o is all-ones and the synchronized up_i is low. borrow_no is low exactly when cnt_o is zero and the synchronized dn_i is low. Both flags are high otherwise.
- R7: When two stages are chained (carry_no to the next stage's up_i, borrow_no to its dn_i, with clear and load shared), the pair counts as one counter of twice the width.
- R8: Except on clear or load, cnt_o changes by at most one per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear, active high, highest priority |
| load_ni | input | 1 | Parallel load enable, active low |
| data_i | input | WIDTH | Value to load |
| up_i | input | 1 | Increment pulse line |
| dn_i | input | 1 | Decrement pulse line |
| cnt_o | output | WIDTH | Current count |
| carry_no | output | 1 | Wrap-up flag, active low |
| borrow_no | output | 1 | Wrap-down flag, active low |

## Verification
The bound checker checks the following on every cycle:
- the effect of clear and load, and that clear wins over load;
- the conditions under which each wrap flag may be low;
- the one-step limit on count changes;
- that the count stays frozen while the opposite line is low.

Only the bench scenarios can show:
- the exact three-edge latency from a line rising to the count changing;
- wrap-around in both directions;
- the carries and borrows into a second chained stage, including the stray pulses into that stage when a stage sits at a boundary and one of its own edges is ignored.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2,
    CNT_LOAD = 2'd3
  } cnt_op_e;

  localparam int unsigned LINE_UP = 0;
  localparam int unsigned LINE_DN = 1;
  localparam int unsigned N_LINES = 2;
endpackage

// File: rtl/ucnt_edge_sync.sv
module ucnt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic held_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Reset to high: idle level of a count line, avoids a spurious edge after reset.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b1;
    else         sync_q[0] <= line_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= 1'b1;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[LAST];
  end

  assign lvl_o  = sync_q[LAST];
  assign rise_o = sync_q[LAST] & ~prev_q;
  assign held_o = sync_q[LAST] & prev_q;
endmodule

// File: rtl/ucnt_core.sv
module ucnt_core
  import ucnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_rise_i,
  input  logic             up_held_i,
  input  logic             dn_rise_i,
  input  logic             dn_held_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  cnt_op_e          op;
  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    op = CNT_HOLD;
    if (!load_ni)                    op = CNT_LOAD;
    else if (up_rise_i && dn_held_i) op = CNT_INC;
    else if (dn_rise_i && up_held_i) op = CNT_DEC;
  end

  always_comb begin
    unique case (op)
      CNT_LOAD: cnt_d = data_i;
      CNT_INC:  cnt_d = cnt_q + ONE;
      CNT_DEC:  cnt_d = cnt_q - ONE;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ucnt_flags.sv
module ucnt_flags #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_lvl_i,
  input  logic             dn_lvl_i,
  output logic             carry_no,
  output logic             borrow_no
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  assign carry_no  = ~((cnt_i == CNT_MAX) & ~up_lvl_i);
  assign borrow_no = ~((cnt_i == '0) & ~dn_lvl_i);
endmodule

// File: rtl/ucnt_cascade.sv
module ucnt_cascade
  import ucnt_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             carry_no,
  output logic             borrow_no
);
  logic [N_LINES-1:0] line_raw, line_lvl, line_rise, line_held;

  assign line_raw[LINE_UP] = up_i;
  assign line_raw[LINE_DN] = dn_i;

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    ucnt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_raw[l]),
      .lvl_o  (line_lvl[l]),
      .rise_o (line_rise[l]),
      .held_o (line_held[l])
    );
  end

  ucnt_core #(.WIDTH(WIDTH)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .load_ni   (load_ni),
    .data_i    (data_i),
    .up_rise_i (line_rise[LINE_UP]),
    .up_held_i (line_held[LINE_UP]),
    .dn_rise_i (line_rise[LINE_DN]),
    .dn_held_i (line_held[LINE_DN]),
    .cnt_o     (cnt_o)
  );

  ucnt_flags #(.WIDTH(WIDTH)) u_flags (
    .cnt_i     (cnt_o),
    .up_lvl_i  (line_lvl[LINE_UP]),
    .dn_lvl_i  (line_lvl[LINE_DN]),
    .carry_no  (carry_no),
    .borrow_no (borrow_no)
  );
endmodule

// File: rtl/ucnt_cascade_chk.sv
module ucnt_cascade_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] cnt_o,
  input logic             carry_no,
  input logic             borrow_no,
  input logic             up_lvl,
  input logic             dn_lvl
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  a_r1_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);

  a_r2_load_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_ni) |=> cnt_o == $past(data_i));

  a_r5_up_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && load_ni && !dn_lvl) |=> $stable(cnt_o));

  a_r5_dn_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && load_ni && !up_lvl) |=> $stable(cnt_o));

  a_r6_carry_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> (cnt_o == {WIDTH{1'b1}} && !up_lvl));

  a_r6_borrow_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !borrow_no |-> (cnt_o == '0 && !dn_lvl));

  a_r8_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && load_ni) |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + ONE
                             || cnt_o == $past(cnt_o) - ONE));
endmodule

bind ucnt_cascade ucnt_cascade_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .load_ni   (load_ni),
  .data_i    (data_i),
  .cnt_o     (cnt_o),
  .carry_no  (carry_no),
  .borrow_no (borrow_no),
  .up_lvl    (line_lvl[0]),
  .dn_lvl    (line_lvl[1])
);

// File: tb/ucnt_cascade_tb.sv
module ucnt_cascade_tb;
  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, load_n = 1'b1;
  logic up = 1'b1, dn = 1'b1;
  logic [W-1:0] data_lo = '0, data_hi = '0;
  logic [W-1:0] cnt_lo, cnt_hi;
  logic c_lo, b_lo, c_hi, b_hi;

  int checks = 0, errors = 0;
  int lo = 0, hi = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ucnt_cascade #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .load_ni(load_n), .data_i(data_lo),
    .up_i(up), .dn_i(dn), .cnt_o(cnt_lo), .carry_no(c_lo), .borrow_no(b_lo));

  ucnt_cascade #(.WIDTH(W)) u_hi (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .load_ni(load_n), .data_i(data_hi),
    .up_i(c_lo), .dn_i(b_lo), .cnt_o(cnt_hi), .carry_no(c_hi), .borrow_no(b_hi));

  function automatic int wrap(input int v);
    return v & MAXV;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_cnt(input string req);
    chk({req, " lo"}, int'(cnt_lo), lo);
    chk({req, " hi"}, int'(cnt_hi), hi);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R3 / R6 / R7: increment pulse with dn held high
  task automatic pulse_up();
    up = 1'b0; cyc(4);
    chk("R6 carry", int'(c_lo), (lo == MAXV) ? 0 : 1);
    up = 1'b1; cyc(2);
    chk("R3 latency", int'(cnt_lo), lo);
    cyc(1);
    if (lo == MAXV) hi = wrap(hi + 1);
    lo = wrap(lo + 1);
    chk("R3 step", int'(cnt_lo), lo);
    cyc(8);
    chk_cnt("R3/R7 up");
  endtask

  // R4 / R6 / R7: decrement pulse with up held high
  task automatic pulse_dn();
    dn = 1'b0; cyc(4);
    chk("R6 borrow", int'(b_lo), (lo == 0) ? 0 : 1);
    dn = 1'b1; cyc(2);
    chk("R4 latency", int'(cnt_lo), lo);
    cyc(1);
    if (lo == 0) hi = wrap(hi - 1);
    lo = wrap(lo - 1);
    chk("R4 step", int'(cnt_lo), lo);
    cyc(8);
    chk_cnt("R4/R7 dn");
  endtask

  // R5: up rises while dn low, then dn rises back while up high
  task automatic ignored_up();
    up = 1'b0; dn = 1'b0; cyc(5);
    up = 1'b1; cyc(10);
    if (lo == MAXV) hi = wrap(hi + 1);
    chk_cnt("R5 up ignored");
    dn = 1'b1; cyc(10);
    if (lo == 0) hi = wrap(hi - 1);
    lo = wrap(lo - 1);
    chk_cnt("R4 restore");
  endtask

  // R5: both lines rise together
  task automatic both_rise();
    up = 1'b0; dn = 1'b0; cyc(5);
    up = 1'b1; dn = 1'b1; cyc(10);
    if (lo == MAXV) hi = wrap(hi + 1);
    else if (lo == 0) hi = wrap(hi - 1);
    chk_cnt("R5 both");
  endtask

  task automatic do_load(input int vlo, input int vhi);
    data_lo = W'(vlo); data_hi = W'(vhi); load_n = 1'b0; cyc(1);
    load_n = 1'b1; lo = vlo; hi = vhi; cyc(1);
    chk_cnt("R2 load");
  endtask

  task automatic do_clear();
    clr = 1'b1; load_n = 1'b0; data_lo = 4'd9; data_hi = 4'd3; cyc(1);
    clr = 1'b0; load_n = 1'b1; lo = 0; hi = 0; cyc(1);
    chk_cnt("R1 clear over load");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    cyc(3);
    chk_cnt("R1 reset");
    chk("R6 carry idle", int'(c_lo), 1);
    chk("R6 borrow idle", int'(b_lo), 1);
    rst_n = 1'b1; cyc(2);

    // directed wrap-around corners
    do_load(MAXV - 1, 2);
    pulse_up(); pulse_up(); pulse_up();
    pulse_dn(); pulse_dn();
    do_load(0, 0);
    pulse_dn();
    do_load(MAXV, 5); ignored_up();
    do_load(0, 7);    ignored_up();
    do_load(MAXV, 1); both_rise();
    do_load(0, 1);    both_rise();

    // R2: load held through a count pulse wins
    data_lo = 4'd6; data_hi = 4'd4; load_n = 1'b0;
    up = 1'b0; cyc(4); up = 1'b1; cyc(4);
    load_n = 1'b1; lo = 6; hi = 4; cyc(8);
    chk_cnt("R2 load over count");
    do_clear();

    for (int i = 0; i < 300; i++) begin
      case ($urandom_range(0, 9))
        0, 1, 2, 3: pulse_up();
        4, 5, 6:    pulse_dn();
        7:          ignored_up();
        8:          both_rise();
        default: begin
          if ($urandom_range(0, 3) == 0) do_clear();
          else do_load(int'($urandom_range(0, MAXV)), int'($urandom_range(0, MAXV)));
        end
      endcase
    end

    // R1: asynchronous reset mid-run
    do_load(9, 9);
    rst_n = 1'b0; #1;
    lo = 0; hi = 0;
    chk_cnt("R1 async reset");
    cyc(2); rst_n = 1'b1; cyc(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule